// File: doc/BRIEF.md
# Execute-Stage Operand Forwarding Unit

This block sits at the two ALU inputs of the execute stage in a five-stage in-order pipeline. The instruction in execute carries two source register numbers and the two operand values it read from the register file during decode. Those values may be stale, because an older instruction may still be in the memory or writeback stage and not yet have written its result. The unit compares each source register number with the destination of the instruction in memory and the destination of the instruction in writeback. For each operand it then either keeps the register-file value or substitutes the newer result.

For each operand the unit produces a 2-bit select code and the selected operand value. The second operand's selected value also serves as the store data, so a store that closely follows the instruction producing its data writes the correct value. The unit is purely combinational. Register-file access, the ALU itself, stall generation and branch resolution belong to other blocks.

Top module: `fwd_unit`

## Requirements
- R1: When neither later stage qualifies as a producer for an operand, that operand's select code is 2'b00 and the operand output equals the register-file value latched from decode.
- R2: When the memory-stage instruction writes a nonzero destination equal to an operand's source register, the select code is 2'b10 and the operand output equals the memory-stage result.
- R3: When only the writeback-stage instruction qualifies (write flag set, nonzero destination equal to the source register), the select code is 2'b01 and the operand output equals the writeback result.
- R4: When both later stages qualify for the same operand, the memory stage wins: the code is 2'b10 and the memory-stage result is used, so a chain of writes to one register delivers the most recent value.
- R5: A stage whose register-write flag is clear never supplies a forward, whatever its destination number is.
- R6: Destination register zero is never forwarded, even when its write flag is set. A source register of zero always receives code 2'b00.
- R7: Operand A is compared only against the first source register and operand B only against the second. The two operands are resolved independently and may take different sources in the same cycle.
- R8: The select code 2'b11 never appears on either operand.
- R9: The operand B output carries the forwarded value, so store data that depends on an older in-flight result receives that result.
- R10: The outputs follow the inputs without any clock: a change to the pipeline-register contents shows at the outputs within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_rs_i | input | 5 | First source register number of the instruction in execute |
| ex_rt_i | input | 5 | Second source register number of the instruction in execute |
| ex_rs_val_i | input | 32 | Register-file value read for the first source |
| ex_rt_val_i | input | 32 | Register-file value read for the second source |
| mem_wr_i | input | 1 | Register-write flag of the instruction in memory |
| mem_rd_i | input | 5 | Destination register number of the instruction in memory |
| mem_res_i | input | 32 | ALU result held in the memory-stage register |
| wb_wr_i | input | 1 | Register-write flag of the instruction in writeback |
| wb_rd_i | input | 5 | Destination register number of the instruction in writeback |
| wb_res_i | input | 32 | Writeback-selected result (load data or ALU result) |
| sel_a_o | output | 2 | Source code for operand A: 00 register file, 01 writeback, 10 memory |
| sel_b_o | output | 2 | Source code for operand B, same encoding |
| opnd_a_o | output | 32 | Selected operand A |
| opnd_b_o | output | 32 | Selected operand B, also the store data |

## Verification
The assertions check on every input change that no operand ever takes code 11 and that each code delivers the value it names. They also check that a register-zero source is never forwarded and that a writeback forward is only chosen when the memory stage does not qualify. Only the bench scenarios show the intended choice for a given instruction sequence. These include the write-flag gating, the same-register chain where the newer result must win, independent resolution of the two operands, store data picking up a forwarded value, and outputs tracking their inputs with no clock edge involved.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

  // Operand source code: the encoding is seen at the block's ports.
  typedef enum logic [1:0] {
    SRC_RF  = 2'b00,
    SRC_WB  = 2'b01,
    SRC_MEM = 2'b10
  } fwd_src_e;

  localparam int unsigned NUM_OPND = 2;

endpackage

// File: rtl/fwd_producer_match.sv
module fwd_producer_match #(
  parameter int unsigned REG_W = 5
) (
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] dst_i,
  input  logic [REG_W-1:0] src_i,
  output logic             hit_o
);

  localparam logic [REG_W-1:0] ZERO_REG = '0;

  logic dst_live;
  logic num_eq;

  always_comb begin
    dst_live = wr_en_i && (dst_i != ZERO_REG);
    num_eq   = (dst_i == src_i);
    hit_o    = dst_live && num_eq;
  end

endmodule

// File: rtl/fwd_sel_arbiter.sv
module fwd_sel_arbiter
  import fwd_pkg::*;
(
  input  logic     mem_hit_i,
  input  logic     wb_hit_i,
  output fwd_src_e sel_o
);

  always_comb begin
    if (mem_hit_i) begin
      sel_o = SRC_MEM;
    end else if (wb_hit_i) begin
      sel_o = SRC_WB;
    end else begin
      sel_o = SRC_RF;
    end
  end

endmodule

// File: rtl/fwd_opnd_mux.sv
module fwd_opnd_mux
  import fwd_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  fwd_src_e          sel_i,
  input  logic [DATA_W-1:0] rf_val_i,
  input  logic [DATA_W-1:0] mem_val_i,
  input  logic [DATA_W-1:0] wb_val_i,
  output logic [DATA_W-1:0] opnd_o
);

  always_comb begin
    unique case (sel_i)
      SRC_MEM: opnd_o = mem_val_i;
      SRC_WB:  opnd_o = wb_val_i;
      default: opnd_o = rf_val_i;
    endcase
  end

endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
  import fwd_pkg::*;
#(
  parameter int unsigned REG_W  = 5,
  parameter int unsigned DATA_W = 32
) (
  input  logic [REG_W-1:0]  ex_rs_i,
  input  logic [REG_W-1:0]  ex_rt_i,
  input  logic [DATA_W-1:0] ex_rs_val_i,
  input  logic [DATA_W-1:0] ex_rt_val_i,
  input  logic              mem_wr_i,
  input  logic [REG_W-1:0]  mem_rd_i,
  input  logic [DATA_W-1:0] mem_res_i,
  input  logic              wb_wr_i,
  input  logic [REG_W-1:0]  wb_rd_i,
  input  logic [DATA_W-1:0] wb_res_i,
  output logic [1:0]        sel_a_o,
  output logic [1:0]        sel_b_o,
  output logic [DATA_W-1:0] opnd_a_o,
  output logic [DATA_W-1:0] opnd_b_o
);

  // Index 0 is operand A (first source), index 1 is operand B (second source).
  logic [REG_W-1:0]  src_num [NUM_OPND];
  logic [DATA_W-1:0] rf_val  [NUM_OPND];
  logic [DATA_W-1:0] opnd    [NUM_OPND];
  fwd_src_e          sel     [NUM_OPND];
  logic              mem_hit [NUM_OPND];
  logic              wb_hit  [NUM_OPND];

  always_comb begin
    src_num[0] = ex_rs_i;
    src_num[1] = ex_rt_i;
    rf_val[0]  = ex_rs_val_i;
    rf_val[1]  = ex_rt_val_i;
  end

  for (genvar g = 0; g < NUM_OPND; g++) begin : g_opnd
    fwd_producer_match #(.REG_W(REG_W)) u_mem_match (
      .wr_en_i (mem_wr_i),
      .dst_i   (mem_rd_i),
      .src_i   (src_num[g]),
      .hit_o   (mem_hit[g])
    );

    fwd_producer_match #(.REG_W(REG_W)) u_wb_match (
      .wr_en_i (wb_wr_i),
      .dst_i   (wb_rd_i),
      .src_i   (src_num[g]),
      .hit_o   (wb_hit[g])
    );

    fwd_sel_arbiter u_arb (
      .mem_hit_i (mem_hit[g]),
      .wb_hit_i  (wb_hit[g]),
      .sel_o     (sel[g])
    );

    fwd_opnd_mux #(.DATA_W(DATA_W)) u_mux (
      .sel_i     (sel[g]),
      .rf_val_i  (rf_val[g]),
      .mem_val_i (mem_res_i),
      .wb_val_i  (wb_res_i),
      .opnd_o    (opnd[g])
    );
  end

  always_comb begin
    sel_a_o  = sel[0];
    sel_b_o  = sel[1];
    opnd_a_o = opnd[0];
    opnd_b_o = opnd[1];
  end

endmodule

// File: rtl/fwd_unit_chk.sv
module fwd_unit_chk #(
  parameter int unsigned REG_W  = 5,
  parameter int unsigned DATA_W = 32
) (
  input logic [REG_W-1:0]  ex_rs_i,
  input logic [REG_W-1:0]  ex_rt_i,
  input logic [DATA_W-1:0] ex_rs_val_i,
  input logic [DATA_W-1:0] ex_rt_val_i,
  input logic              mem_wr_i,
  input logic [REG_W-1:0]  mem_rd_i,
  input logic [DATA_W-1:0] mem_res_i,
  input logic              wb_wr_i,
  input logic [REG_W-1:0]  wb_rd_i,
  input logic [DATA_W-1:0] wb_res_i,
  input logic [1:0]        sel_a_o,
  input logic [1:0]        sel_b_o,
  input logic [DATA_W-1:0] opnd_a_o,
  input logic [DATA_W-1:0] opnd_b_o
);

  always_comb begin
    // R8
    sel_legal_chk: assert (sel_a_o != 2'b11 && sel_b_o != 2'b11);
    // R2
    if (sel_a_o == 2'b10) a_mem_val_chk: assert (opnd_a_o == mem_res_i);
    // R2
    if (sel_b_o == 2'b10) b_mem_val_chk: assert (opnd_b_o == mem_res_i);
    // R3
    if (sel_a_o == 2'b01) a_wb_val_chk: assert (opnd_a_o == wb_res_i);
    // R3
    if (sel_b_o == 2'b01) b_wb_val_chk: assert (opnd_b_o == wb_res_i);
    // R1
    if (sel_a_o == 2'b00) a_rf_val_chk: assert (opnd_a_o == ex_rs_val_i);
    // R1
    if (sel_b_o == 2'b00) b_rf_val_chk: assert (opnd_b_o == ex_rt_val_i);
    // R6
    if (ex_rs_i == '0) a_zero_src_chk: assert (sel_a_o == 2'b00);
    // R6
    if (ex_rt_i == '0) b_zero_src_chk: assert (sel_b_o == 2'b00);
    // R4
    if (sel_a_o == 2'b01) a_wb_prio_chk:
      assert (!(mem_wr_i && mem_rd_i == ex_rs_i));
    // R4
    if (sel_b_o == 2'b01) b_wb_prio_chk:
      assert (!(mem_wr_i && mem_rd_i == ex_rt_i));
  end

endmodule

bind fwd_unit fwd_unit_chk #(.REG_W(REG_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_fwd_unit.sv
module sim_fwd_unit;

  logic clk;
  logic rst_n;

  logic [4:0]  ex_rs, ex_rt, mem_rd, wb_rd;
  logic [31:0] ex_rs_val, ex_rt_val, mem_res, wb_res;
  logic        mem_wr, wb_wr;
  logic [1:0]  sel_a, sel_b;
  logic [31:0] opnd_a, opnd_b;

  int n_chk;
  int n_fail;
  bit done;

  fwd_unit u0 (
    .ex_rs_i     (ex_rs),
    .ex_rt_i     (ex_rt),
    .ex_rs_val_i (ex_rs_val),
    .ex_rt_val_i (ex_rt_val),
    .mem_wr_i    (mem_wr),
    .mem_rd_i    (mem_rd),
    .mem_res_i   (mem_res),
    .wb_wr_i     (wb_wr),
    .wb_rd_i     (wb_rd),
    .wb_res_i    (wb_res),
    .sel_a_o     (sel_a),
    .sel_b_o     (sel_b),
    .opnd_a_o    (opnd_a),
    .opnd_b_o    (opnd_b)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic set_pipe(input logic [4:0] rs, input logic [4:0] rt,
                          input logic mwr, input logic [4:0] mrd,
                          input logic wwr, input logic [4:0] wrd);
    @(posedge clk);
    ex_rs = rs; ex_rt = rt;
    mem_wr = mwr; mem_rd = mrd;
    wb_wr = wwr; wb_rd = wrd;
    @(negedge clk);
  endtask

  // Expected code from the requirements (R2..R6)
  function automatic logic [1:0] exp_sel(input logic [4:0] src, input logic mwr,
      input logic [4:0] mrd, input logic wwr, input logic [4:0] wrd);
    if (mwr && mrd != 5'd0 && mrd == src) return 2'b10;
    if (wwr && wrd != 5'd0 && wrd == src) return 2'b01;
    return 2'b00;
  endfunction

  function automatic logic [31:0] exp_val(input logic [1:0] s, input logic [31:0] rf);
    case (s)
      2'b10:   return mem_res;
      2'b01:   return wb_res;
      default: return rf;
    endcase
  endfunction

  task automatic t_reset;
    chk("R1", "reset sel_a", {30'd0, sel_a}, 32'd0);
    chk("R1", "reset sel_b", {30'd0, sel_b}, 32'd0);
    chk("R1", "reset opnd_a", opnd_a, ex_rs_val);
    chk("R1", "reset opnd_b", opnd_b, ex_rt_val);
  endtask

  task automatic t_no_match;
    set_pipe(5'd3, 5'd4, 1'b1, 5'd5, 1'b1, 5'd6);
    chk("R1", "no match sel_a", {30'd0, sel_a}, 32'd0);
    chk("R1", "no match sel_b", {30'd0, sel_b}, 32'd0);
    chk("R1", "no match opnd_a", opnd_a, ex_rs_val);
    chk("R1", "no match opnd_b", opnd_b, ex_rt_val);
  endtask

  task automatic t_mem_fwd;
    set_pipe(5'd3, 5'd4, 1'b1, 5'd3, 1'b0, 5'd4);
    chk("R2", "mem fwd sel_a", {30'd0, sel_a}, 32'd2);
    chk("R2", "mem fwd opnd_a", opnd_a, mem_res);
    chk("R5", "wb flag clear sel_b", {30'd0, sel_b}, 32'd0);
  endtask

  task automatic t_wb_store;
    // store data on operand B picks up a writeback result
    set_pipe(5'd8, 5'd4, 1'b1, 5'd9, 1'b1, 5'd4);
    chk("R3", "wb fwd sel_b", {30'd0, sel_b}, 32'd1);
    chk("R9", "store data opnd_b", opnd_b, wb_res);
    chk("R1", "unmatched opnd_a", opnd_a, ex_rs_val);
  endtask

  task automatic t_chain;
    set_pipe(5'd1, 5'd1, 1'b1, 5'd1, 1'b1, 5'd1);
    chk("R4", "chain sel_a", {30'd0, sel_a}, 32'd2);
    chk("R4", "chain sel_b", {30'd0, sel_b}, 32'd2);
    chk("R4", "chain opnd_a newest", opnd_a, mem_res);
    chk("R4", "chain opnd_b newest", opnd_b, mem_res);
  endtask

  task automatic t_wr_flag;
    set_pipe(5'd3, 5'd3, 1'b0, 5'd3, 1'b1, 5'd3);
    chk("R5", "mem flag clear falls to wb", {30'd0, sel_a}, 32'd1);
    chk("R5", "mem flag clear opnd_a", opnd_a, wb_res);
    set_pipe(5'd3, 5'd3, 1'b0, 5'd3, 1'b0, 5'd3);
    chk("R5", "both flags clear sel_a", {30'd0, sel_a}, 32'd0);
    chk("R5", "both flags clear opnd_b", opnd_b, ex_rt_val);
  endtask

  task automatic t_zero_reg;
    set_pipe(5'd0, 5'd0, 1'b1, 5'd0, 1'b1, 5'd0);
    chk("R6", "zero reg sel_a", {30'd0, sel_a}, 32'd0);
    chk("R6", "zero reg sel_b", {30'd0, sel_b}, 32'd0);
    chk("R6", "zero reg opnd_a", opnd_a, ex_rs_val);
    chk("R6", "zero reg opnd_b", opnd_b, ex_rt_val);
  endtask

  task automatic t_cross;
    set_pipe(5'd7, 5'd9, 1'b1, 5'd9, 1'b1, 5'd7);
    chk("R7", "cross sel_a", {30'd0, sel_a}, 32'd1);
    chk("R7", "cross sel_b", {30'd0, sel_b}, 32'd2);
    chk("R7", "cross opnd_a", opnd_a, wb_res);
    chk("R7", "cross opnd_b", opnd_b, mem_res);
  endtask

  task automatic t_no_clock;
    set_pipe(5'd12, 5'd13, 1'b0, 5'd12, 1'b0, 5'd13);
    #0.5;
    mem_wr = 1'b1;
    #0.5;
    chk("R10", "same-cycle sel_a", {30'd0, sel_a}, 32'd2);
    chk("R10", "same-cycle opnd_a", opnd_a, mem_res);
  endtask

  task automatic t_sweep;
    for (int s = 0; s < 8; s++) begin
      for (int m = 0; m < 8; m++) begin
        for (int w = 0; w < 8; w++) begin
          for (int f = 0; f < 4; f++) begin
            logic [1:0] ea, eb;
            set_pipe(5'(s), 5'(7 - s), f[1], 5'(m), f[0], 5'(w));
            ea = exp_sel(5'(s), f[1], 5'(m), f[0], 5'(w));
            eb = exp_sel(5'(7 - s), f[1], 5'(m), f[0], 5'(w));
            chk("R8", "sweep sel_a", {30'd0, sel_a}, {30'd0, ea});
            chk("R8", "sweep sel_b", {30'd0, sel_b}, {30'd0, eb});
            chk("R7", "sweep opnd_a", opnd_a, exp_val(ea, ex_rs_val));
            chk("R7", "sweep opnd_b", opnd_b, exp_val(eb, ex_rt_val));
          end
        end
      end
    end
  endtask

  initial begin
    #40000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0;
    ex_rs = '0; ex_rt = '0; mem_wr = 1'b0; mem_rd = '0; wb_wr = 1'b0; wb_rd = '0;
    ex_rs_val = 32'h1111_AAAA; ex_rt_val = 32'h2222_BBBB;
    mem_res = 32'hDEAD_0010; wb_res = 32'hBEEF_0001;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_no_match();
    t_mem_fwd();
    t_wb_store();
    t_chain();
    t_wr_flag();
    t_zero_reg();
    t_cross();
    t_no_clock();
    t_sweep();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule